// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block decides, cycle by cycle, whether a decoded floating-point operation can leave the integer pipeline. The arithmetic is not computed here. The block tracks when each operation's result will be ready. Two execution resources sit behind it:

- a fully pipelined path, whose results can be consumed four cycles after issue;
- a single divide/square-root unit that takes one operation at a time, with a latency and a re-issue interval that depend on the operation.

A countdown per register catches read-after-write and write-after-write conflicts. A countdown on the divider catches a second divide arriving too early. The issue stall is raised only when one of these conflicts exists, or when the pending-operation queue is full or an exception is outstanding.

Every accepted operation is entered, in order, into an eight-entry queue of operations that have not yet retired. An entry retires from the head once its own latency has elapsed. When an exception is signalled on an input, the queue freezes and further issue is refused. Software then drains the queue oldest-first through a pop interface that returns each entry's operation class and destination register. The block also reports a constant status version value of 2.

Top module: `fpsb_issue_ctrl`

## Requirements
- R1: After synchronous reset: `iss_hold`, `div_busy`, `exc_pending` and `pop_valid` are 0, and `q_count` is 0.
- R2: `fsr_version` always reads 2.
- R3: Operations of class 0 (pipelined; class codes 5 to 7 behave the same) whose sources and destination are not busy are accepted on consecutive cycles without a stall.
- R4: A pipelined operation accepted in cycle t makes its destination busy. An operation reading that register is stalled until cycle t+4 and is accepted in that cycle.
- R5: An operation whose destination register is still busy is stalled (write-after-write).
- R6: The latencies from issue to a dependent being accepted are 16 cycles for class 1 (single divide), 17 for class 2 (double divide), 24 for class 3 (single square root) and 25 for class 4 (double square root).
- R7: After a divide/square-root operation is accepted in cycle t, a second one is stalled until cycle t+14, t+15, t+22 or t+23 for classes 1 to 4 respectively. `div_busy` is high during this window. Pipelined operations keep being accepted while the divider is busy.
- R8: Each accepted operation enters the queue, and `q_count` counts the entries. Entries retire strictly from the oldest, each no earlier than its latency allows. With 8 entries held, a new operation is stalled.
- R9: A pulse on `exc_inject` sets `exc_pending` from the next cycle. While it is set, every presented operation is stalled and no entry retires on its own.
- R10: While `exc_pending` is set and the queue is not empty, `pop_valid` is 1 and `pop_op`/`pop_rd` show the oldest entry. `pop_req` removes it at the clock edge. One cycle after the queue becomes empty, `exc_pending` clears.
- R11: `iss_hold` is 0 whenever `iss_valid` is 0, even if the presented indices name busy registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is presented this cycle |
| iss_op | input | 3 | Operation class |
| iss_rs1 | input | 5 | First source register |
| iss_rs2 | input | 5 | Second source register |
| iss_rd | input | 5 | Destination register |
| iss_hold | output | 1 | Stall the integer pipeline |
| iss_accept | output | 1 | Operation taken at this edge |
| exc_inject | input | 1 | Signal an FP exception |
| exc_pending | output | 1 | Exception outstanding, queue frozen |
| pop_req | input | 1 | Remove the oldest queue entry |
| pop_valid | output | 1 | Oldest entry available to pop |
| pop_op | output | 3 | Class of the oldest entry |
| pop_rd | output | 5 | Destination of the oldest entry |
| q_count | output | 4 | Number of queued operations |
| div_busy | output | 1 | Divider re-issue window active |
| fsr_version | output | 3 | Constant status version |

## Verification
A register countdown that is wrong by one cycle shows at once in the cycle where a dependent operation is accepted. The bench measures that cycle for every class, so an error in the latency or interval tables gives a wrong count on the first dependent issue. A queue pointer or count fault shows within a few cycles. It appears as a `q_count` that fails to hold at 8 behind a long square root, or as the wrong class and destination appearing at the pop port during a drain. An exception flag that does not stick or does not clear shows as an accepted operation, or as a stall that persists, in the cycles right after the drain.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

    localparam int REG_W   = 5;
    localparam int CNT_W   = 5;
    localparam int PIPE_LAT = 4;
    localparam int VERSION = 2;

    typedef enum logic [2:0] {
        CL_PIPE  = 3'd0,
        CL_DIVS  = 3'd1,
        CL_DIVD  = 3'd2,
        CL_SQRTS = 3'd3,
        CL_SQRTD = 3'd4,
        CL_RSV5  = 3'd5,
        CL_RSV6  = 3'd6,
        CL_RSV7  = 3'd7
    } fp_class_e;

    typedef struct packed {
        fp_class_e        op;
        logic [REG_W-1:0] rd;
        logic [CNT_W-1:0] rem;
    } tq_entry_t;

    function automatic logic uses_div(input fp_class_e c);
        return (c == CL_DIVS) || (c == CL_DIVD) || (c == CL_SQRTS) || (c == CL_SQRTD);
    endfunction

    // cycles from issue until a dependent may issue
    function automatic logic [CNT_W-1:0] lat_of(input fp_class_e c);
        case (c)
            CL_DIVS:  return CNT_W'(16);
            CL_DIVD:  return CNT_W'(17);
            CL_SQRTS: return CNT_W'(24);
            CL_SQRTD: return CNT_W'(25);
            default:  return CNT_W'(PIPE_LAT);
        endcase
    endfunction

    // cycles from a divider issue until the divider accepts again
    function automatic logic [CNT_W-1:0] gap_of(input fp_class_e c);
        case (c)
            CL_DIVS:  return CNT_W'(14);
            CL_DIVD:  return CNT_W'(15);
            CL_SQRTS: return CNT_W'(22);
            CL_SQRTD: return CNT_W'(23);
            default:  return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/fpsb_scoreboard.sv
module fpsb_scoreboard
    import fpsb_pkg::*;
#(
    parameter int RW   = REG_W,
    parameter int CW   = CNT_W,
    localparam int NREG = 1 << RW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  logic [CW-1:0] wr_val,
    input  logic [RW-1:0] rs1,
    input  logic [RW-1:0] rs2,
    input  logic [RW-1:0] rd,
    output logic          conflict
);

    logic [CW-1:0]   cnt [NREG];
    logic [NREG-1:0] bsy;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (wr_en && (wr_idx == RW'(g))) begin
                cnt[g] <= wr_val;
            end else if (cnt[g] != '0) begin
                cnt[g] <= cnt[g] - CW'(1);
            end
        end
        assign bsy[g] = (cnt[g] != '0);
    end

    // read-after-write on either source, write-after-write on destination
    assign conflict = bsy[rs1] | bsy[rs2] | bsy[rd];

    // R5: a write never lands on a register still in flight
    assert_no_waw_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !bsy[wr_idx]);

    // R4: the written register reads busy in the following cycle
    assert_busy_after_issue_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> bsy[$past(wr_idx)]);

endmodule

// File: rtl/fpsb_divtrack.sv
module fpsb_divtrack
    import fpsb_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] gap,
    output logic          busy
);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (start) begin
            left <= gap - CW'(1);
        end else if (left != '0) begin
            left <= left - CW'(1);
        end
    end

    assign busy = (left != '0);

    // R7: the divider never takes a second operation inside its window
    assert_single_occupancy_R7: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R7: the window counts down one per cycle
    assert_window_steps_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (left == $past(left) - CW'(1)));

endmodule

// File: rtl/fpsb_trapq.sv
module fpsb_trapq
    import fpsb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int QCW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq,
    input  tq_entry_t        enq_ent,
    input  logic             deq,
    output logic             full,
    output logic             empty,
    output logic [QCW-1:0]   count,
    output tq_entry_t        head_ent,
    output logic             head_done
);

    tq_entry_t        ent [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [PW-1:0]    head, tail;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                vld[i] <= 1'b0;
                ent[i] <= '0;
            end else if (enq && (tail == PW'(i))) begin
                vld[i] <= 1'b1;
                ent[i] <= enq_ent;
            end else begin
                if (deq && (head == PW'(i))) vld[i] <= 1'b0;
                if (vld[i] && (ent[i].rem != '0)) ent[i].rem <= ent[i].rem - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (enq) tail <= bump(tail);
            if (deq) head <= bump(head);
            count <= count + QCW'(enq) - QCW'(deq);
        end
    end

    assign full      = (count == QCW'(DEPTH));
    assign empty     = (count == '0);
    assign head_ent  = ent[head];
    assign head_done = vld[head] && (ent[head].rem == '0);

    // R8: never written past capacity
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        enq |-> !full);

    // R8: never removed from an empty queue
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        deq |-> !empty);

    // R8: the count stays within capacity
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        count <= QCW'(DEPTH));

endmodule

// File: rtl/fpsb_issue_ctrl.sv
module fpsb_issue_ctrl
    import fpsb_pkg::*;
#(
    parameter int QDEPTH = 8,
    localparam int QCW   = $clog2(QDEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid,
    input  logic [2:0]       iss_op,
    input  logic [REG_W-1:0] iss_rs1,
    input  logic [REG_W-1:0] iss_rs2,
    input  logic [REG_W-1:0] iss_rd,
    output logic             iss_hold,
    output logic             iss_accept,
    input  logic             exc_inject,
    output logic             exc_pending,
    input  logic             pop_req,
    output logic             pop_valid,
    output logic [2:0]       pop_op,
    output logic [REG_W-1:0] pop_rd,
    output logic [QCW-1:0]   q_count,
    output logic             div_busy,
    output logic [2:0]       fsr_version
);

    fp_class_e  cls;
    logic       is_div;
    logic       reg_conflict;
    logic       q_full, q_empty, q_head_done;
    tq_entry_t  new_ent, head_ent;
    logic       retire, pop_fire, deq;

    assign cls    = fp_class_e'(iss_op);
    assign is_div = uses_div(cls);

    fpsb_scoreboard #(.RW(REG_W), .CW(CNT_W)) u_sb (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (iss_accept),
        .wr_idx   (iss_rd),
        .wr_val   (lat_of(cls) - CNT_W'(1)),
        .rs1      (iss_rs1),
        .rs2      (iss_rs2),
        .rd       (iss_rd),
        .conflict (reg_conflict)
    );

    fpsb_divtrack #(.CW(CNT_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (iss_accept && is_div),
        .gap   (gap_of(cls)),
        .busy  (div_busy)
    );

    always_comb begin
        new_ent.op  = cls;
        new_ent.rd  = iss_rd;
        new_ent.rem = lat_of(cls) - CNT_W'(1);
    end

    fpsb_trapq #(.DEPTH(QDEPTH)) u_q (
        .clk       (clk),
        .rst       (rst),
        .enq       (iss_accept),
        .enq_ent   (new_ent),
        .deq       (deq),
        .full      (q_full),
        .empty     (q_empty),
        .count     (q_count),
        .head_ent  (head_ent),
        .head_done (q_head_done)
    );

    assign iss_hold   = iss_valid && (reg_conflict || (is_div && div_busy) || q_full || exc_pending);
    assign iss_accept = iss_valid && !iss_hold;

    assign retire    = !exc_pending && q_head_done;
    assign pop_valid = exc_pending && !q_empty;
    assign pop_fire  = pop_req && pop_valid;
    assign deq       = retire || pop_fire;
    assign pop_op    = head_ent.op;
    assign pop_rd    = head_ent.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_pending <= 1'b0;
        end else if (exc_inject) begin
            exc_pending <= 1'b1;
        end else if (exc_pending && q_empty) begin
            exc_pending <= 1'b0;
        end
    end

    assign fsr_version = 3'(VERSION);

    // R9: nothing issues while an exception is outstanding
    assert_no_issue_in_trap_R9: assert property (@(posedge clk) disable iff (rst)
        exc_pending |-> !iss_accept);

    // R9: the queue only shrinks through pops while frozen
    assert_frozen_queue_R9: assert property (@(posedge clk) disable iff (rst)
        (exc_pending && !pop_req) |=> (q_count == $past(q_count)));

    // R10: an exception with an empty queue clears one cycle later
    assert_trap_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (exc_pending && q_empty && !exc_inject) |=> !exc_pending);

    // R11: the stall never appears without a presented operation
    assert_hold_needs_valid_R11: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> !iss_hold);

endmodule

// File: tb/fpsb_issue_ctrl_tb.sv
module fpsb_issue_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       iss_valid;
    logic [2:0] iss_op;
    logic [4:0] iss_rs1, iss_rs2, iss_rd;
    logic       iss_hold, iss_accept;
    logic       exc_inject, exc_pending;
    logic       pop_req, pop_valid;
    logic [2:0] pop_op;
    logic [4:0] pop_rd;
    logic [3:0] q_count;
    logic       div_busy;
    logic [2:0] fsr_version;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsb_issue_ctrl u_dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_rs1(iss_rs1), .iss_rs2(iss_rs2), .iss_rd(iss_rd),
        .iss_hold(iss_hold), .iss_accept(iss_accept),
        .exc_inject(exc_inject), .exc_pending(exc_pending),
        .pop_req(pop_req), .pop_valid(pop_valid),
        .pop_op(pop_op), .pop_rd(pop_rd),
        .q_count(q_count), .div_busy(div_busy),
        .fsr_version(fsr_version)
    );

    // class, dependent latency, divider re-issue gap
    localparam int NROW = 5;
    localparam int T_OP  [NROW] = '{0, 1, 2, 3, 4};
    localparam int T_LAT [NROW] = '{4, 16, 17, 24, 25};
    localparam int T_GAP [NROW] = '{1, 14, 15, 22, 23};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic present(input int op, input int rs1, input int rs2, input int rd);
        iss_valid = 1'b1;
        iss_op    = 3'(op);
        iss_rs1   = 5'(rs1);
        iss_rs2   = 5'(rs2);
        iss_rd    = 5'(rd);
    endtask

    task automatic idle(input int n);
        iss_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // issue a first op, then retry a second until taken; k = cycles between the two accepts
    task automatic measure(input int op1, input int rd1,
                           input int op2, input int rs, input int rd2, output int k);
        @(negedge clk);
        present(op1, 30, 31, rd1);
        #1;
        check("setup accept", int'(iss_accept), 1);
        @(negedge clk);
        present(op2, rs, 31, rd2);
        k = 0;
        for (int n = 0; n < 100; n++) begin
            k++;
            #1;
            if (iss_accept) break;
            @(negedge clk);
        end
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        rst = 1'b1; iss_valid = 1'b0; iss_op = '0;
        iss_rs1 = '0; iss_rs2 = '0; iss_rd = '0;
        exc_inject = 1'b0; pop_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 hold",    int'(iss_hold), 0);
        check("R1 q_count", int'(q_count), 0);
        check("R1 div_busy", int'(div_busy), 0);
        check("R1 exc_pending", int'(exc_pending), 0);
        check("R1 pop_valid", int'(pop_valid), 0);
        // R2 version
        check("R2 version", int'(fsr_version), 2);

        // table walk: dependent latency (R4, R6) and re-issue gap (R7, R3)
        for (int r = 0; r < NROW; r++) begin
            measure(T_OP[r], 1, 0, 1, 2, k);
            check(r == 0 ? "R4 raw latency" : "R6 div latency", k, T_LAT[r]);
            idle(60);
            measure(T_OP[r], 3, T_OP[r], 30, 4, k);
            check(r == 0 ? "R3 pipe back-to-back" : "R7 div gap", k, T_GAP[r]);
            idle(60);
        end

        // R3 six independent ops, one per cycle
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            present(5 + (i % 3), 30, 31, 10 + i);
            #1;
            check("R3 independent accept", int'(iss_accept), 1);
        end
        idle(20);

        // R5 write-after-write, then R11 busy index without valid
        @(negedge clk); present(0, 30, 31, 7);
        @(negedge clk); present(0, 30, 31, 7); #1;
        check("R5 waw hold", int'(iss_hold), 1);
        @(negedge clk); iss_valid = 1'b0; iss_rs1 = 5'd7; #1;
        check("R11 no hold without valid", int'(iss_hold), 0);
        idle(20);

        // R7 / R8: long square root at head, seven pipelined ops behind it
        @(negedge clk); present(4, 30, 31, 2);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); present(0, 30, 31, 10 + i); #1;
            check("R7 pipe during divide", int'(iss_accept), 1);
        end
        @(negedge clk); present(0, 30, 31, 17); #1;
        check("R7 div_busy", int'(div_busy), 1);
        check("R8 full count", int'(q_count), 8);
        check("R8 full hold", int'(iss_hold), 1);
        idle(10); #1;
        check("R8 in-order retire", int'(q_count), 8);
        idle(40); #1;
        check("R8 drained", int'(q_count), 0);

        // R9 / R10: exception with three queued ops
        @(negedge clk); present(0, 30, 31, 3);
        @(negedge clk); present(1, 30, 31, 4);
        @(negedge clk); present(0, 30, 31, 5);
        @(negedge clk); iss_valid = 1'b0; exc_inject = 1'b1;
        @(negedge clk); exc_inject = 1'b0; #1;
        check("R9 pending", int'(exc_pending), 1);
        check("R9 queued", int'(q_count), 3);
        present(0, 30, 31, 20); #1;
        check("R9 issue blocked", int'(iss_hold), 1);
        idle(10); #1;
        check("R9 frozen", int'(q_count), 3);
        check("R10 pop_valid", int'(pop_valid), 1);
        check("R10 pop_op 0", int'(pop_op), 0);
        check("R10 pop_rd 0", int'(pop_rd), 3);
        pop_req = 1'b1;
        @(negedge clk); #1;
        check("R10 pop_op 1", int'(pop_op), 1);
        check("R10 pop_rd 1", int'(pop_rd), 4);
        @(negedge clk); #1;
        check("R10 pop_op 2", int'(pop_op), 0);
        check("R10 pop_rd 2", int'(pop_rd), 5);
        @(negedge clk); pop_req = 1'b0; #1;
        check("R10 empty", int'(q_count), 0);
        check("R10 pop_valid low", int'(pop_valid), 0);
        check("R10 still pending", int'(exc_pending), 1);
        @(negedge clk); #1;
        check("R10 cleared", int'(exc_pending), 0);
        @(negedge clk); present(0, 30, 31, 21); #1;
        check("R10 issue resumes", int'(iss_accept), 1);
        idle(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule